// File: doc/BRIEF.md
# Bayer Pixel Gain Steering Sequencer

This block picks, for every pixel sample of a sensor readout, which one of four per-colour gain words drives the downstream gain stage. The choice follows a two-by-two colour mosaic. Along a line the selection swaps between the two members of a channel pair on every pixel strobe. At each line boundary the block moves to the other pair. A field boundary sends it back to the first pair, so every field starts on the same colour row.

The four gain words arrive on one packed input. The block holds a shadow copy of them and takes new values only at a field boundary. Gain changes that software makes during readout therefore apply from the next field on, never part way through one. A mode input can switch steering off; the block then applies the channel 0 gain to every pixel, while the pattern state keeps advancing in the background. The outputs are registered and change only on a pixel strobe, one clock after it.

Top module: `bayer_gain_steer`

## Requirements
- R1: Two clocks after a synchronous active-high reset, `chan_out` and `gain_out` read 0. The pattern is on pair 0 with the even phase, and all four shadow gains are 0 until the first field-boundary capture.
- R2: While `pix_en` is low, `chan_out` and `gain_out` keep their values.
- R3: A clock with `pix_en` high updates the outputs on that clock edge. They are visible one clock later. `chan_out` is the selected channel index, and `gain_out` is the shadow gain of that channel as it stands after the edge.
- R4: Within a line, the phase (bit 0 of `chan_out`) alternates 0,1,0,1 on successive strobes. A `hc_rst` pulse returns the phase to 0. A strobe in the same clock as `hc_rst` gets phase 0.
- R5: A falling edge on `hd` (high on one clock, low on the next) toggles the pair (bit 1 of `chan_out`). Pair 0 is channels 0 and 1; pair 1 is channels 2 and 3. The channel index is {pair, phase}.
- R6: A falling edge on `vd` forces the pair to 0. This takes priority over an `hd` falling edge in the same clock and applies to a strobe in that same clock.
- R7: Channel k of `gain_in` is bits [9k+8:9k]. The shadow gains load from `gain_in` only in the clock of a `vd` falling edge, and a strobe in that clock already sees the new values. Changes of `gain_in` at any other time do not affect `gain_out`.
- R8: With `steer_en` low, a strobe outputs channel 0 and its shadow gain. The pair and phase state still advances, so re-enabling steering continues the pattern where it stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel strobe, one per sample |
| vd | input | 1 | Vertical (field) sync; falling edge marks a field start |
| hd | input | 1 | Horizontal (line) sync; falling edge marks a line start |
| hc_rst | input | 1 | Horizontal counter reset pulse; realigns the phase |
| steer_en | input | 1 | 1 = colour steering, 0 = channel 0 always |
| gain_in | input | 36 | Four 9-bit gain words, channel k at [9k+8:9k] |
| gain_out | output | 9 | Selected gain code |
| chan_out | output | 2 | Selected channel index {pair, phase} |

## Verification
A wrong pair bit first shows up at the first strobe after a line or field boundary: `chan_out[1]` and the gain word belong to the wrong colour row, one clock after that strobe. A stuck or skipped phase shows within two strobes as a repeated low bit of `chan_out`. A shadow copy that loads at the wrong time shows as a `gain_out` change that follows `gain_in` in the middle of a field. A stale copy shows as the old gain on the first strobe of a new field. Because the bench compares against its reference on every clock, each of these faults is reported in the clock where it first reaches the ports.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  // Channel index layout: pair selects the colour row, phase the column.
  typedef struct packed {
    logic pair;
    logic phase;
  } chan_sel_t;
endpackage

// File: rtl/bgs_fall_det.sv
module bgs_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig;
  end

  assign fall = sig_q & ~sig;
endmodule

// File: rtl/bgs_gain_bank.sv
module bgs_gain_bank #(
  parameter int unsigned GAIN_W = 9,
  parameter int unsigned NUM_CH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [NUM_CH*GAIN_W-1:0] gain_in,
  output logic [NUM_CH*GAIN_W-1:0] gain_eff,
  output logic [NUM_CH*GAIN_W-1:0] shadow
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int unsigned LO = k * GAIN_W;

    always_ff @(posedge clk) begin
      if (rst)       shadow[LO +: GAIN_W] <= '0;
      else if (load) shadow[LO +: GAIN_W] <= gain_in[LO +: GAIN_W];
    end

    // A strobe in the capture cycle already uses the incoming word.
    assign gain_eff[LO +: GAIN_W] = load ? gain_in[LO +: GAIN_W]
                                         : shadow[LO +: GAIN_W];
  end
endmodule

// File: rtl/bgs_pattern.sv
module bgs_pattern
  import bgs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      vd_fall,
  input  logic      hd_fall,
  input  logic      hc_rst,
  input  logic      pix_en,
  output chan_sel_t sel_eff
);
  logic pair_q;
  logic phase_q;
  logic pair_eff;
  logic phase_eff;

  // Field start beats line start; counter reset realigns the column.
  always_comb begin
    if (vd_fall)      pair_eff = 1'b0;
    else if (hd_fall) pair_eff = ~pair_q;
    else              pair_eff = pair_q;
    phase_eff = hc_rst ? 1'b0 : phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      pair_q  <= pair_eff;
      phase_q <= pix_en ? ~phase_eff : phase_eff;
    end
  end

  assign sel_eff = '{pair: pair_eff, phase: phase_eff};
endmodule

// File: rtl/bayer_gain_steer.sv
module bayer_gain_steer
  import bgs_pkg::*;
#(
  parameter int unsigned GAIN_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic              vd,
  input  logic              hd,
  input  logic              hc_rst,
  input  logic              steer_en,
  input  logic [4*GAIN_W-1:0] gain_in,
  output logic [GAIN_W-1:0] gain_out,
  output logic [1:0]        chan_out
);
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned BUS_W  = NUM_CH * GAIN_W;

  logic             vd_fall;
  logic             hd_fall;
  logic [BUS_W-1:0] gain_eff;
  logic [BUS_W-1:0] shadow_flat;
  chan_sel_t        sel_eff;
  logic [1:0]       nxt_chan;
  logic [GAIN_W-1:0] gain_arr [NUM_CH];

  bgs_fall_det u_vd_det (.clk(clk), .rst(rst), .sig(vd), .fall(vd_fall));
  bgs_fall_det u_hd_det (.clk(clk), .rst(rst), .sig(hd), .fall(hd_fall));

  bgs_gain_bank #(.GAIN_W(GAIN_W), .NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst(rst), .load(vd_fall), .gain_in(gain_in),
    .gain_eff(gain_eff), .shadow(shadow_flat)
  );

  bgs_pattern u_pat (
    .clk(clk), .rst(rst), .vd_fall(vd_fall), .hd_fall(hd_fall),
    .hc_rst(hc_rst), .pix_en(pix_en), .sel_eff(sel_eff)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_arr
    assign gain_arr[k] = gain_eff[k*GAIN_W +: GAIN_W];
  end

  assign nxt_chan = steer_en ? sel_eff : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_out <= 2'd0;
      gain_out <= '0;
    end else if (pix_en) begin
      chan_out <= nxt_chan;
      gain_out <= gain_arr[nxt_chan];
    end
  end
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
  parameter int unsigned GAIN_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_en,
  input logic              vd,
  input logic              hc_rst,
  input logic              steer_en,
  input logic [4*GAIN_W-1:0] shadow_flat,
  input logic [GAIN_W-1:0] gain_out,
  input logic [1:0]        chan_out
);
  logic              ck_vdq;
  logic              field_edge;
  logic [GAIN_W-1:0] sh [4];

  always_ff @(posedge clk) begin
    if (rst) ck_vdq <= 1'b0;
    else     ck_vdq <= vd;
  end
  assign field_edge = ck_vdq & ~vd;

  always_comb begin
    for (int k = 0; k < 4; k++) sh[k] = shadow_flat[k*GAIN_W +: GAIN_W];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (chan_out == 2'd0 && gain_out == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(chan_out) && $stable(gain_out)));

  assert_gain_match_R3: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> (gain_out == sh[chan_out]));

  assert_line_start_even_R4: assert property (@(posedge clk) disable iff (rst)
    (hc_rst && pix_en && steer_en) |=> (chan_out[0] == 1'b0));

  assert_field_pair_R6: assert property (@(posedge clk) disable iff (rst)
    (field_edge && pix_en && steer_en) |=> (chan_out[1] == 1'b0));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !field_edge |=> $stable(shadow_flat));

  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !steer_en) |=> (chan_out == 2'd0));
endmodule

bind bayer_gain_steer bgs_checker #(.GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .vd(vd), .hc_rst(hc_rst),
  .steer_en(steer_en), .shadow_flat(shadow_flat),
  .gain_out(gain_out), .chan_out(chan_out)
);

// File: tb/sim_bayer_gain_steer.sv
module sim_bayer_gain_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_en = 1'b0, vd = 1'b0, hd = 1'b0, hc_rst = 1'b0, steer_en = 1'b1;
  logic [35:0] gain_in = '0;
  logic [8:0]  gain_out;
  logic [1:0]  chan_out;

  int checks = 0, fails = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R3";

  // behavioural reference
  int m_vdq, m_hdq, m_pair, m_ph, m_chan, m_gain;
  int m_sh [4];

  always #5 clk = ~clk;

  bayer_gain_steer u0 (
    .clk(clk), .rst(rst), .pix_en(pix_en), .vd(vd), .hd(hd), .hc_rst(hc_rst),
    .steer_en(steer_en), .gain_in(gain_in), .gain_out(gain_out), .chan_out(chan_out)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_vdq = 0; m_hdq = 0; m_pair = 0; m_ph = 0; m_chan = 0; m_gain = 0;
      for (int k = 0; k < 4; k++) m_sh[k] = 0;
    end else begin
      bit vf, hf;
      vf = (m_vdq == 1) && !vd;
      hf = (m_hdq == 1) && !hd;
      if (vf) begin
        m_pair = 0;
        for (int k = 0; k < 4; k++) m_sh[k] = int'(gain_in[k*9 +: 9]);
      end else if (hf) m_pair = 1 - m_pair;
      if (hc_rst) m_ph = 0;
      if (pix_en) begin
        m_chan = steer_en ? (m_pair * 2 + m_ph) : 0;
        m_gain = m_sh[m_chan];
        m_ph = 1 - m_ph;
      end
      m_vdq = vd; m_hdq = hd;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      checks++;
      if (int'(chan_out) != m_chan || int'(gain_out) != m_gain) begin
        fails++;
        $display("FAIL %s model: chan=%0d gain=%0d expected chan=%0d gain=%0d",
                 cur_req, chan_out, gain_out, m_chan, m_gain);
      end
    end
  end

  task automatic expect_out(input int ch, input int g, input string req);
    checks++;
    if (int'(chan_out) != ch || int'(gain_out) != g) begin
      fails++;
      $display("FAIL %s: chan=%0d gain=%0d expected chan=%0d gain=%0d",
               req, chan_out, gain_out, ch, g);
    end
  endtask

  // apply one clock of inputs at the falling edge, return at the next one
  task automatic cyc(input bit p, input bit v, input bit h, input bit c);
    pix_en = p; vd = v; hd = h; hc_rst = c;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out(0, 0, "R1");               // reset state
    cmp_on = 1;
    gain_in = {9'd400, 9'd300, 9'd200, 9'd100};
    cyc(1, 0, 0, 0);
    expect_out(0, 0, "R7");               // no capture yet: shadow still zero (R1)
    cyc(1, 0, 0, 0);
    expect_out(1, 0, "R1");               // phase advanced from even
    cyc(0, 1, 0, 0);
    cur_req = "R6";
    cyc(1, 0, 0, 1);                      // field edge + counter reset + strobe
    expect_out(0, 100, "R6");
    cyc(1, 0, 0, 0);
    expect_out(1, 200, "R4");
    cur_req = "R2";
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    expect_out(1, 200, "R2");
    cur_req = "R5";
    cyc(0, 0, 1, 0);
    cyc(1, 0, 0, 0);                      // line edge with strobe
    expect_out(2, 300, "R5");
    cyc(1, 0, 0, 0);
    expect_out(3, 400, "R5");
    cur_req = "R7";
    gain_in = {9'd511, 9'd7, 9'd256, 9'd1};
    cyc(1, 0, 0, 0);
    expect_out(2, 300, "R7");             // new words ignored mid-field
    cyc(0, 0, 1, 0);
    cyc(1, 0, 0, 1);                      // back to pair 0, phase even
    expect_out(0, 100, "R4");
    cur_req = "R6";
    cyc(0, 1, 1, 0);
    cyc(1, 0, 0, 1);                      // both edges: field wins, pair 0
    expect_out(0, 1, "R6");
    cur_req = "R8";
    steer_en = 1'b0;
    cyc(1, 0, 0, 0);
    expect_out(0, 1, "R8");
    cyc(1, 0, 0, 0);
    expect_out(0, 1, "R8");
    steer_en = 1'b1;
    cyc(1, 0, 0, 0);
    expect_out(1, 256, "R8");             // pattern kept advancing while bypassed
    cur_req = "R3";
    for (int i = 0; i < 6000; i++) begin
      gain_in = {$urandom, $urandom};
      if ($urandom % 150 == 0) steer_en = ~steer_en;
      cyc(($urandom % 4) != 0,
          ($urandom % 97 == 0) ? ~vd : vd,
          ($urandom % 19 == 0) ? ~hd : hd,
          ($urandom % 13 == 0));
    end
    cur_req = "R1";
    rst = 1'b1;
    cyc(1, 1, 1, 0);
    rst = 1'b0;
    cyc(0, 0, 0, 0);
    expect_out(0, 0, "R1");
    finish_run();
  end
endmodule